// File: doc/BRIEF.md
# Serial Receive Character Assembler with Status Word

This block sits behind a start-bit verifier in an asynchronous serial receiver. The verifier owns the oversampling. It raises a one-cycle `start_ok_i` pulse when it has confirmed a start bit at its centre. After that, it raises a one-cycle `bit_stb_i` pulse with the sampled level on `bit_val_i` once per bit cell. The block counts these strobes against the frame shape set by the configuration inputs. That shape is the data length, whether a parity bit is present and of which sense, and whether there are one or two stop bits. The shape must match the far-end transmitter.

The block shifts the data bits, least significant first, into a shift register. It checks the parity bit and the stop bit or bits. When the last stop bit arrives, it copies the assembled character in parallel into a holding register and raises the data-available flag. A host polls the flags through a gated status word. It reads the character through a gated data port. It then pulses a clear input to release the holding register. While the host is still working on one character, the next one can already be shifting in.

Top module: `rx_char_status`

## Requirements
- R1: The length code `cfg_len_i` selects DATA_W-3+code data bits (5, 6, 7 or 8 at the defaults). The data bits are received least significant bit first. If `cfg_par_en_i` is set, one parity bit follows the data: even when `cfg_par_odd_i` is 0, odd when it is 1. One stop bit follows, or two when `cfg_two_stop_i` is set. The configuration is captured on the `start_ok_i` pulse.
- R2: A `bit_stb_i` pulse while no frame is open has no effect. A `start_ok_i` pulse while a frame is open has no effect on that frame.
- R3: On the clock edge that samples the final stop-bit strobe, the holding register loads the character, zero-extended to DATA_W bits. The data-available flag is 1 from the next cycle.
- R4: While `sw_en_i` is 1, `stat_o` shows the flags: bit 0 data-available, bit 1 parity error, bit 2 framing error, bit 3 overrun. While `sw_en_i` is 0, `stat_o` is 0.
- R5: While `rd_en_i` is 1, `data_o` shows the holding register. While `rd_en_i` is 0, `data_o` is 0.
- R6: A `rda_clr_i` pulse clears data-available and all three error flags. If a transfer happens in the same cycle, the transfer wins: data-available is set and overrun is not flagged.
- R7: With parity enabled, the parity error flag is set on transfer when the ones count over the data bits and the parity bit does not match the chosen sense. With parity disabled, the flag stays 0.
- R8: The framing error flag is set on transfer when any sampled stop bit is 0.
- R9: A transfer while data-available is set, with no clear in that cycle, sets the overrun flag. The new character replaces the old one.
- R10: While the next character is being shifted in, the holding register and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_ok_i | input | 1 | Verified start bit pulse |
| bit_stb_i | input | 1 | Bit-centre sample strobe |
| bit_val_i | input | 1 | Sampled line level |
| cfg_len_i | input | LEN_W | Data length code |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Parity sense, 1 = odd |
| cfg_two_stop_i | input | 1 | Two stop bits |
| sw_en_i | input | 1 | Status word enable |
| rd_en_i | input | 1 | Data read enable |
| rda_clr_i | input | 1 | Data-available clear pulse |
| stat_o | output | 4 | Status word {overrun, framing, parity, available} |
| data_o | output | DATA_W | Received character |

## Verification
The bench builds the block with DATA_W=8 and LEN_W=2, so there are only four lengths. This lets the bench sweep every combination of length, parity mode (none, even, odd) and stop-bit count, which is 24 frame shapes. Each shape is sent with several data patterns, with a corrupted parity bit and with a zero stop bit. The expected flags and data are computed arithmetically from the mask and the ones count. The small configuration also brings within reach the cases that depend on ordering: overrun, a clear in the transfer cycle, stray strobes, and a look at the holding register during the next frame.

// File: rtl/rx_char_pkg.sv
package rx_char_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_DATA,
        FS_PAR,
        FS_STOP1,
        FS_STOP2
    } frame_st_e;

    typedef struct packed {
        logic ovr;
        logic ferr;
        logic perr;
        logic avail;
    } stat_flags_t;

endpackage

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import rx_char_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             cfg_two_stop,
    input  logic             par_acc,
    output logic             shift_en,
    output logic             clear_sr,
    output logic             xfer,
    output logic             xfer_perr,
    output logic             xfer_ferr,
    output logic [CNT_W-1:0] frame_len
);

    localparam int MIN_LEN = DATA_W - (1 << LEN_W) + 1;

    typedef struct packed {
        frame_st_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] len;
        logic             par_en;
        logic             par_odd;
        logic             two_stop;
        logic             perr;
        logic             ferr;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  stop_err;

    always_comb begin
        r_d       = r_q;
        shift_en  = 1'b0;
        clear_sr  = 1'b0;
        xfer      = 1'b0;
        xfer_perr = r_q.perr;
        xfer_ferr = r_q.ferr;
        stop_err  = r_q.ferr | ~bit_val;
        unique case (r_q.st)
            FS_IDLE: begin
                if (start_ok) begin
                    r_d.st       = FS_DATA;
                    r_d.cnt      = '0;
                    r_d.len      = CNT_W'(MIN_LEN) + CNT_W'(cfg_len);
                    r_d.par_en   = cfg_par_en;
                    r_d.par_odd  = cfg_par_odd;
                    r_d.two_stop = cfg_two_stop;
                    r_d.perr     = 1'b0;
                    r_d.ferr     = 1'b0;
                    clear_sr     = 1'b1;
                end
            end
            FS_DATA: begin
                if (bit_stb) begin
                    shift_en = 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == r_q.len - 1'b1) begin
                        r_d.st = r_q.par_en ? FS_PAR : FS_STOP1;
                    end
                end
            end
            FS_PAR: begin
                if (bit_stb) begin
                    r_d.perr = par_acc ^ bit_val ^ r_q.par_odd;
                    r_d.st   = FS_STOP1;
                end
            end
            FS_STOP1: begin
                if (bit_stb) begin
                    if (r_q.two_stop) begin
                        r_d.ferr = stop_err;
                        r_d.st   = FS_STOP2;
                    end else begin
                        xfer      = 1'b1;
                        xfer_ferr = stop_err;
                        r_d.st    = FS_IDLE;
                    end
                end
            end
            FS_STOP2: begin
                if (bit_stb) begin
                    xfer      = 1'b1;
                    xfer_ferr = stop_err;
                    r_d.st    = FS_IDLE;
                end
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: FS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign frame_len = r_q.len;

endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              bit_val,
    input  logic [CNT_W-1:0]  len,
    output logic              par_acc,
    output logic [DATA_W-1:0] word
);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              acc;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.sr  = '0;
            s_d.acc = 1'b0;
        end else if (shift_en) begin
            s_d.sr  = {bit_val, s_q.sr[DATA_W-1:1]};
            s_d.acc = s_q.acc ^ bit_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign par_acc = s_q.acc;
    assign word    = s_q.sr >> (CNT_W'(DATA_W) - len);

endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import rx_char_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              xfer_perr,
    input  logic              xfer_ferr,
    input  logic              rda_clr,
    input  logic              sw_en,
    input  logic              rd_en,
    output logic [3:0]        stat_o,
    output logic [DATA_W-1:0] data_o,
    output stat_flags_t       flags_o
);

    typedef struct packed {
        logic [DATA_W-1:0] buf_data;
        stat_flags_t       fl;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (xfer) begin
            h_d.buf_data = xfer_data;
            h_d.fl.avail = 1'b1;
            h_d.fl.perr  = xfer_perr;
            h_d.fl.ferr  = xfer_ferr;
            h_d.fl.ovr   = h_q.fl.avail & ~rda_clr;
        end else if (rda_clr) begin
            h_d.fl = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign stat_o  = sw_en ? h_q.fl : 4'b0;
    assign data_o  = rd_en ? h_q.buf_data : '0;
    assign flags_o = h_q.fl;

endmodule

// File: rtl/rx_char_status.sv
module rx_char_status
    import rx_char_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok_i,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_two_stop_i,
    input  logic              sw_en_i,
    input  logic              rd_en_i,
    input  logic              rda_clr_i,
    output logic [3:0]        stat_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              shift_en;
    logic              clear_sr;
    logic              xfer;
    logic              xfer_perr;
    logic              xfer_ferr;
    logic              par_acc;
    logic [CNT_W-1:0]  frame_len;
    logic [DATA_W-1:0] rx_word;
    stat_flags_t       flags;

    rx_frame_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_ok    (start_ok_i),
        .bit_stb     (bit_stb_i),
        .bit_val     (bit_val_i),
        .cfg_len     (cfg_len_i),
        .cfg_par_en  (cfg_par_en_i),
        .cfg_par_odd (cfg_par_odd_i),
        .cfg_two_stop(cfg_two_stop_i),
        .par_acc     (par_acc),
        .shift_en    (shift_en),
        .clear_sr    (clear_sr),
        .xfer        (xfer),
        .xfer_perr   (xfer_perr),
        .xfer_ferr   (xfer_ferr),
        .frame_len   (frame_len)
    );

    rx_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_sr),
        .shift_en(shift_en),
        .bit_val (bit_val_i),
        .len     (frame_len),
        .par_acc (par_acc),
        .word    (rx_word)
    );

    rx_holding #(.DATA_W(DATA_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer),
        .xfer_data(rx_word),
        .xfer_perr(xfer_perr),
        .xfer_ferr(xfer_ferr),
        .rda_clr  (rda_clr_i),
        .sw_en    (sw_en_i),
        .rd_en    (rd_en_i),
        .stat_o   (stat_o),
        .data_o   (data_o),
        .flags_o  (flags)
    );

endmodule

// File: rtl/rx_char_status_chk.sv
module rx_char_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_en,
    input logic              rd_en,
    input logic              rda_clr,
    input logic [3:0]        stat,
    input logic [DATA_W-1:0] data,
    input logic              xfer,
    input logic [3:0]        flags
);

    p_stat_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> stat == 4'b0);

    p_data_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> data == '0);

    p_xfer_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> flags[0]);

    p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rda_clr && !xfer) |=> flags == 4'b0);

    p_clear_loses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rda_clr && xfer) |=> (flags[0] && !flags[3]));

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && flags[0] && !rda_clr) |=> flags[3]);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !rda_clr) |=> $stable(flags));

endmodule

bind rx_char_status rx_char_status_chk #(.DATA_W(DATA_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_en  (sw_en_i),
    .rd_en  (rd_en_i),
    .rda_clr(rda_clr_i),
    .stat   (stat_o),
    .data   (data_o),
    .xfer   (xfer),
    .flags  (flags)
);

// File: tb/test_rx_char_status.sv
module test_rx_char_status;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_ok = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       sw_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       rda_clr = 1'b0;
    logic [3:0] stat;
    logic [7:0] data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rx_char_status #(.DATA_W(8), .LEN_W(2)) i_rx_char_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_ok_i    (start_ok),
        .bit_stb_i     (bit_stb),
        .bit_val_i     (bit_val),
        .cfg_len_i     (cfg_len),
        .cfg_par_en_i  (cfg_par_en),
        .cfg_par_odd_i (cfg_par_odd),
        .cfg_two_stop_i(cfg_two_stop),
        .sw_en_i       (sw_en),
        .rd_en_i       (rd_en),
        .rda_clr_i     (rda_clr),
        .stat_o        (stat),
        .data_o        (data)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic read_stat(output logic [3:0] s);
        @(negedge clk);
        sw_en = 1'b1;
        #1 s = stat;
        sw_en = 1'b0;
    endtask

    task automatic read_data(output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        #1 d = data;
        rd_en = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        rda_clr = 1'b1;
        @(negedge clk);
        rda_clr = 1'b0;
    endtask

    task automatic strobe(input logic v, input bit with_clr);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = v;
        rda_clr = with_clr;
        @(negedge clk);
        bit_stb = 1'b0;
        bit_val = 1'b1;
        rda_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input int lc, input bit pen, input bit podd, input bit two,
                              input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit clr_end, input bit mid_start, input bit peek,
                              input logic [7:0] prev);
        int         len;
        logic [7:0] mask;
        logic       pbit;
        logic [7:0] pk;
        len  = 5 + lc;
        mask = 8'((1 << len) - 1);
        @(negedge clk);
        cfg_len      = 2'(lc);
        cfg_par_en   = pen;
        cfg_par_odd  = podd;
        cfg_two_stop = two;
        start_ok     = 1'b1;
        @(negedge clk);
        start_ok     = 1'b0;
        // config changes after capture must not matter (R1)
        cfg_len      = 2'(lc + 1);
        cfg_par_en   = ~pen;
        cfg_two_stop = ~two;
        for (int i = 0; i < len; i++) begin
            strobe(d[i], 1'b0);
            if (i == 1 && mid_start) begin
                @(negedge clk);
                start_ok = 1'b1;
                @(negedge clk);
                start_ok = 1'b0;
            end
            if (i == 1 && peek) begin
                read_data(pk);
                check("R10", "holding data during next frame", int'(pk), int'(prev));
            end
        end
        if (pen) begin
            pbit = (^(d & mask)) ^ podd ^ bad_par;
            strobe(pbit, 1'b0);
        end
        if (two) begin
            strobe(~bad_stop, 1'b0);
            strobe(1'b1, clr_end);
        end else begin
            strobe(~bad_stop, clr_end);
        end
    endtask

    task automatic expect_char(input string req, input logic [3:0] es, input logic [7:0] ed);
        logic [3:0] s;
        logic [7:0] d;
        read_stat(s);
        check(req, "status word", int'(s), int'(es));
        read_data(d);
        check(req, "character", int'(d), int'(ed));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] s;
        logic [7:0] d;
        logic [7:0] pats [4];
        pats[0] = 8'h00;
        pats[1] = 8'hFF;
        pats[2] = 8'hA5;
        pats[3] = 8'h5A;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state (R4, R5)
        read_stat(s);
        check("R4", "status after reset", int'(s), 0);
        read_data(d);
        check("R5", "data after reset", int'(d), 0);

        // stray strobes in idle have no effect (R2)
        strobe(1'b0, 1'b0);
        strobe(1'b1, 1'b0);
        read_stat(s);
        check("R2", "status after idle strobes", int'(s), 0);

        // full sweep of frame shapes (R1, R3, R7, R8, R6)
        for (int lc = 0; lc < 4; lc++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    logic [7:0] mask;
                    bit         pen;
                    bit         podd;
                    mask = 8'((1 << (5 + lc)) - 1);
                    pen  = (pm != 0);
                    podd = (pm == 2);
                    for (int k = 0; k < 4; k++) begin
                        logic [7:0] v;
                        v = pats[k] ^ 8'(k * 37 + lc * 11 + pm);
                        send_frame(lc, pen, podd, two[0], v, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
                        expect_char("R1", 4'b0001, v & mask);
                        pulse_clear();
                        read_stat(s);
                        check("R6", "status after clear", int'(s), 0);
                    end
                    if (pen) begin
                        send_frame(lc, pen, podd, two[0], 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
                        expect_char("R7", 4'b0011, 8'h3C & mask);
                        pulse_clear();
                    end
                    send_frame(lc, pen, podd, two[0], 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
                    expect_char("R8", 4'b0101, 8'hC3 & mask);
                    pulse_clear();
                    read_stat(s);
                    check("R6", "errors cleared", int'(s), 0);
                end
            end
        end

        // second stop bit low alone is a framing error (R8)
        begin
            @(negedge clk);
            cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b1;
            start_ok = 1'b1;
            @(negedge clk);
            start_ok = 1'b0;
            for (int i = 0; i < 8; i++) strobe(1'(i % 2), 1'b0);
            strobe(1'b1, 1'b0);
            strobe(1'b0, 1'b0);
            expect_char("R8", 4'b0101, 8'hAA);
            pulse_clear();
        end

        // start pulse inside a frame is ignored (R2)
        send_frame(3, 1'b1, 1'b0, 1'b0, 8'h96, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
        expect_char("R2", 4'b0001, 8'h96);

        // gating while a character is held (R4, R5)
        @(negedge clk);
        #1 check("R4", "status gated off", int'(stat), 0);
        check("R5", "data gated off", int'(data), 0);

        // next frame assembles while old one is held, then overrun (R10, R9)
        send_frame(3, 1'b0, 1'b0, 1'b0, 8'h71, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h96);
        expect_char("R9", 4'b1001, 8'h71);
        pulse_clear();
        read_stat(s);
        check("R9", "overrun cleared", int'(s), 0);

        // clear in the same cycle as transfer: transfer wins, no overrun (R6)
        send_frame(2, 1'b0, 1'b0, 1'b0, 8'h15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        send_frame(1, 1'b1, 1'b1, 1'b1, 8'h2E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        expect_char("R6", 4'b0001, 8'h2E);
        pulse_clear();

        // transfer into an empty holding register after clear: no overrun (R3)
        send_frame(0, 1'b0, 1'b0, 1'b0, 8'h1F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        expect_char("R3", 4'b0001, 8'h1F);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule